// File: doc/BRIEF.md
# Stereo Window Pre-processing Unit

This block accepts a raster stream of 8-bit luminance pixels for one camera image. For every pixel it builds a 7x7 neighbourhood from six line buffers and a register matrix. It then reduces that neighbourhood to a 12-bit descriptor that the stereo matcher further down consumes. The descriptor holds three fields. The first is a class that picks the aggregation window size from local texture, measured as the mean absolute deviation of all 49 pixels. The second is a six-bit census signature. The third is a four-bit segment code, taken from the vertical run of similar pixels through the centre. The left and right images each have their own instance.

Frames arrive back to back and are not framed by side signals. The block counts raster position itself. Each output describes the pixel that entered 3W+3 accepted beats earlier. Near the frame edges, window positions that fall outside the image are replaced by the nearest pixel inside it. The tail of a frame therefore leaves the block while the head of the next frame enters. After the last frame, 3W+3 extra beats push out its last outputs.

Top module: `stereo_prep_window`

## Requirements
- R1: `out_word` is laid out as bits [11:10] window class, bits [9:4] census signature and bits [3:0] segment code.
- R2: The mean is (S*1337)>>16, where S is the sum of the 49 window pixels. MAD is the sum of |p - mean| over the 49 pixels. The class equals the number of thresholds among `mad_lim0`, `mad_lim1` and `mad_lim2` that MAD strictly exceeds. A larger class selects a smaller window.
- R3: A census bit is 1 exactly when the neighbour is strictly less than the centre. With offsets written as (row, column) from the centre, bit 9 is (-2,-2), bit 8 is (-2,+2), bit 7 is (0,-3), bit 6 is (0,+3), bit 5 is (+2,-2) and bit 4 is (+2,+2).
- R4: Bits [3:2] count the consecutive pixels directly above the centre, at rows -1, -2 and -3 in that order, whose absolute difference from the centre is at most 8. The count stops at the first pixel that fails. Bits [1:0] count the same way downward, at rows +1, +2 and +3.
- R5: A window position outside the image takes the pixel at the clamped row and clamped column. Each axis is clamped to the image independently.
- R6: Beat number 3W+3 after reset, counting from 0, produces the first output, for pixel (0,0). Every later accepted beat produces exactly one output. Each output appears with `out_valid` three clock cycles after its beat. Idle cycles on `in_valid` do not change any result.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_word` is 0.
- R8: Row 0 of the next frame follows the last row of a frame directly. Outputs of one frame never use pixels of a neighbouring frame.
- R9: `out_word` keeps its value on every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel beat strobe |
| in_pix | input | PW | Luminance of the beat |
| mad_lim0 | input | MW | First deviation threshold |
| mad_lim1 | input | MW | Second deviation threshold |
| mad_lim2 | input | MW | Third deviation threshold |
| out_valid | output | 1 | Descriptor strobe |
| out_word | output | 12 | Packed descriptor |

## Verification
The bench aims at the corners of the image. A clamp that is off by one, or missing, would pull pixels from the previous row, the previous frame or stale line-buffer contents into those windows, and the border fields would then differ. A flat frame puts MAD exactly on a threshold and puts every census comparison on equality. A design that compared with "greater or equal", or that set a census bit on equal values, would report the wrong class or a nonzero census. Frames sent back to back, and a stream with idle cycles, would expose leaks between frames, dropped or duplicated strobes, and a wrong delay from beat to output.

// File: rtl/stereo_prep_window.sv
module stereo_prep_window #(
  parameter int W      = 64,
  parameter int H      = 48,
  parameter int PW     = 8,
  parameter int SEG_TH = 8,
  parameter int RECIP  = 1337,
  parameter int RSH    = 16,
  localparam int MW    = $clog2(49 * ((1 << PW) - 1) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] in_pix,
  input  logic [MW-1:0] mad_lim0,
  input  logic [MW-1:0] mad_lim1,
  input  logic [MW-1:0] mad_lim2,
  output logic          out_valid,
  output logic [11:0]   out_word
);
  localparam int D   = 3 * W + 3;
  localparam int XW  = $clog2(W);
  localparam int YW  = $clog2(H);
  localparam int FW  = $clog2(D + 1);
  localparam int PRW = MW + RSH;

  logic [PW-1:0] lb  [6][W];
  logic [PW-1:0] tap [7];
  logic [PW-1:0] raw [7][7];
  logic [PW-1:0] win [7][7];
  logic [PW-1:0] win_q [7][7];
  logic [2:0]    rs [7];
  logic [2:0]    cs [7];
  logic [XW-1:0] wp, cc;
  logic [YW-1:0] cr;
  logic [FW-1:0] fc;
  logic          v0, v1;
  logic [MW-1:0] sum_c, sum_q, mad_c;
  logic [PRW-1:0] prod;
  logic [PW-1:0] mean_c, ctr;
  logic [5:0]    cen_c;
  logic [1:0]    up_c, dn_c, cls_c;

  wire primed = (fc == FW'(D));

  assign tap[6] = in_pix;
  for (genvar k = 0; k < 6; k++) begin : g_tap
    assign tap[5-k] = lb[k][wp];
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lb[0][wp] <= in_pix;
      for (int k = 1; k < 6; k++) lb[k][wp] <= lb[k-1][wp];
      for (int r = 0; r < 7; r++) begin
        raw[r][0] <= tap[r];
        for (int j = 1; j < 7; j++) raw[r][j] <= raw[r][j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      fc <= '0;
      cr <= YW'(H - 1);
      cc <= XW'(W - 1);
      v0 <= 1'b0;
    end else begin
      v0 <= in_valid && primed;
      if (in_valid) begin
        wp <= (wp == XW'(W - 1)) ? '0 : wp + XW'(1);
        if (!primed) fc <= fc + FW'(1);
        else if (cc == XW'(W - 1)) begin
          cc <= '0;
          cr <= (cr == YW'(H - 1)) ? '0 : cr + YW'(1);
        end else cc <= cc + XW'(1);
      end
    end
  end

  always_comb begin
    for (int a = 0; a < 7; a++) begin
      int t;
      t = int'(cr) + a - 3;
      if (t < 0) t = 0;
      if (t > H - 1) t = H - 1;
      rs[a] = 3'(t - int'(cr) + 3);
    end
    for (int b = 0; b < 7; b++) begin
      int t;
      t = int'(cc) + b - 3;
      if (t < 0) t = 0;
      if (t > W - 1) t = W - 1;
      cs[b] = 3'(3 - (t - int'(cc)));
    end
  end

  always_comb begin
    sum_c = '0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) begin
        win[a][b] = raw[rs[a]][cs[b]];
        sum_c = sum_c + MW'(win[a][b]);
      end
  end

  always_ff @(posedge clk) begin
    win_q <= win;
    sum_q <= sum_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= v0;
  end

  function automatic logic near(input logic [PW-1:0] p, input logic [PW-1:0] c);
    return ((p > c) ? p - c : c - p) <= PW'(SEG_TH);
  endfunction

  assign prod   = PRW'(sum_q) * PRW'(RECIP);
  assign mean_c = PW'(prod >> RSH);
  assign ctr    = win_q[3][3];

  always_comb begin
    mad_c = '0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        mad_c = mad_c + MW'((win_q[a][b] > mean_c) ? win_q[a][b] - mean_c
                                                  : mean_c - win_q[a][b]);
  end

  assign cen_c = {win_q[1][1] < ctr, win_q[1][5] < ctr, win_q[3][0] < ctr,
                  win_q[3][6] < ctr, win_q[5][1] < ctr, win_q[5][5] < ctr};

  always_comb begin
    up_c = 2'd0;
    if (near(win_q[2][3], ctr)) begin
      up_c = 2'd1;
      if (near(win_q[1][3], ctr)) begin
        up_c = 2'd2;
        if (near(win_q[0][3], ctr)) up_c = 2'd3;
      end
    end
    dn_c = 2'd0;
    if (near(win_q[4][3], ctr)) begin
      dn_c = 2'd1;
      if (near(win_q[5][3], ctr)) begin
        dn_c = 2'd2;
        if (near(win_q[6][3], ctr)) dn_c = 2'd3;
      end
    end
  end

  assign cls_c = 2'(mad_c > mad_lim0) + 2'(mad_c > mad_lim1) + 2'(mad_c > mad_lim2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_word <= {cls_c, cen_c, up_c, dn_c};
    end
  end
endmodule

module stereo_prep_window_chk #(
  parameter int W  = 64,
  parameter int PW = 8,
  localparam int MW = $clog2(49 * ((1 << PW) - 1) + 1),
  localparam int D  = 3 * W + 3,
  localparam int FW = $clog2(D + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [FW-1:0] fc,
  input logic [MW-1:0] mad_lim0,
  input logic [MW-1:0] mad_lim1,
  input logic [MW-1:0] mad_lim2,
  input logic          out_valid,
  input logic [11:0]   out_word
);
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_word == 12'd0));

  assert_beat_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fc == FW'(D)) |=> ##2 out_valid);

  assert_no_orphan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  assert_primed_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == FW'(D)) |=> (fc == FW'(D)));

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));

  assert_class_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mad_lim0) == '1 && $past(mad_lim1) == '1 && $past(mad_lim2) == '1)
      |-> out_word[11:10] == 2'd0);
endmodule

bind stereo_prep_window stereo_prep_window_chk #(.W(W), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fc(fc),
  .mad_lim0(mad_lim0), .mad_lim1(mad_lim1), .mad_lim2(mad_lim2),
  .out_valid(out_valid), .out_word(out_word));

// File: tb/stereo_prep_window_test.sv
module stereo_prep_window_test;
  localparam int BW = 10, BH = 7, WH = BW * BH, BD = 3 * BW + 3, MAXN = 4 * WH;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b1, in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic [13:0] lim0 = '0, lim1 = '0, lim2 = '0;
  wire out_valid;
  wire [11:0] out_word;

  stereo_prep_window #(.W(BW), .H(BH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .mad_lim0(lim0), .mad_lim1(lim1), .mad_lim2(lim2),
    .out_valid(out_valid), .out_word(out_word));

  always #5 clk = ~clk;

  int pix [MAXN];
  int got [MAXN];
  int gcyc [MAXN];
  int nin = 0, ng = 0, cyc = 0, dcyc = 0, checks = 0, errors = 0;
  logic [11:0] last = '0;
  bit have_last = 0;

  function void check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL R6 watchdog: actual %0d cycles expected fewer than %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) have_last = 0;
    else if (out_valid) begin
      if (ng < MAXN) begin
        got[ng] = int'(out_word);
        gcyc[ng] = cyc;
      end
      ng++;
      last = out_word;
      have_last = 1;
    end else if (have_last) check("R9 word held while idle", int'(out_word), int'(last));
  end

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int clampi(int x, int hi);
    return (x < 0) ? 0 : ((x > hi) ? hi : x);
  endfunction

  function automatic int model(int base, int r, int c);
    int w [7][7];
    int sum = 0, mean, mad = 0, cls, cz, cen, up = 0, dn = 0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) begin
        w[a][b] = pix[base + clampi(r + a - 3, BH - 1) * BW + clampi(c + b - 3, BW - 1)];
        sum += w[a][b];
      end
    mean = (sum * 1337) >>> 16;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) mad += iabs(w[a][b] - mean);
    cls = int'(mad > int'(lim0)) + int'(mad > int'(lim1)) + int'(mad > int'(lim2));
    cz = w[3][3];
    cen = (int'(w[1][1] < cz) << 5) | (int'(w[1][5] < cz) << 4) | (int'(w[3][0] < cz) << 3) |
          (int'(w[3][6] < cz) << 2) | (int'(w[5][1] < cz) << 1) | int'(w[5][5] < cz);
    if (iabs(w[2][3] - cz) <= 8) begin
      up = 1;
      if (iabs(w[1][3] - cz) <= 8) begin
        up = 2;
        if (iabs(w[0][3] - cz) <= 8) up = 3;
      end
    end
    if (iabs(w[4][3] - cz) <= 8) begin
      dn = 1;
      if (iabs(w[5][3] - cz) <= 8) begin
        dn = 2;
        if (iabs(w[6][3] - cz) <= 8) dn = 3;
      end
    end
    return (cls << 10) | (cen << 4) | (up << 2) | dn;
  endfunction

  function automatic int pattern(int mode, int r, int c);
    case (mode)
      0: return 100;
      1: return int'($urandom_range(0, 255));
      2: return ((r + c) % 2 == 1) ? 255 : 0;
      3: return (r * 30 + c * 11) % 256;
      default: return (r < 3) ? 60 : ((r < 5) ? 64 : 200);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 out_valid during reset", int'(out_valid), 0);
    check("R7 out_word during reset", int'(out_word), 0);
    nin = 0;
    ng = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(int v, bit gap);
    in_pix = 8'(v);
    in_valid = 1'b1;
    if (nin == BD) dcyc = cyc;
    pix[nin] = v;
    nin++;
    @(negedge clk);
    if (gap) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic feed(int mode, int nframes, bit gaps);
    for (int f = 0; f < nframes; f++)
      for (int r = 0; r < BH; r++)
        for (int c = 0; c < BW; c++) push(pattern(mode, r, c), gaps && (nin % 3 == 2));
    for (int i = 0; i < BD; i++) push(255, 1'b0);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic verify(string name, int nframes);
    check({name, " R6 output count"}, ng, nframes * WH);
    for (int k = 0; k < nframes * WH && k < ng; k++) begin
      int f, r, c, e;
      string t;
      f = k / WH;
      r = (k % WH) / BW;
      c = k % BW;
      e = model(f * WH, r, c);
      t = $sformatf("%s%s%s f%0d r%0d c%0d", name,
                    (r < 3 || r > BH - 4 || c < 3 || c > BW - 4) ? " R5" : "",
                    (nframes > 1) ? " R8" : "", f, r, c);
      check({t, " R2 class"}, got[k] >> 10, e >> 10);
      check({t, " R3 census"}, (got[k] >> 4) & 63, (e >> 4) & 63);
      check({t, " R4 segment"}, got[k] & 15, e & 15);
    end
    check({name, " R1 packed word"}, got[WH / 2], model(0, (WH / 2) / BW, (WH / 2) % BW));
  endtask

  task automatic t_latency();
    do_reset();
    for (int i = 0; i <= BD; i++) push(i, 1'b0);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 single output after first full window", ng, 1);
    check("R6 cycles from beat to strobe", gcyc[0] - dcyc, 3);
  endtask

  task automatic t_flat_boundary();
    do_reset();
    lim0 = 14'd49; lim1 = 14'd48; lim2 = 14'd50;
    feed(0, 1, 1'b0);
    verify("flat", 1);
    check("R2 MAD equal to threshold not counted", got[35] >> 10, 1);
    check("R1 flat word fields", got[35], 12'h40F);
    check("R3 equal neighbours give zero census", (got[0] >> 4) & 63, 0);
  endtask

  task automatic t_random();
    do_reset();
    lim0 = 14'd1500; lim1 = 14'd2500; lim2 = 14'd3500;
    feed(1, 1, 1'b0);
    verify("random", 1);
  endtask

  task automatic t_checker();
    do_reset();
    lim0 = 14'd1000; lim1 = 14'd2000; lim2 = 14'd4000;
    feed(2, 1, 1'b0);
    verify("checker", 1);
    check("R2 strong texture picks smallest window", got[3 * BW + 4] >> 10, 3);
  endtask

  task automatic t_gradient();
    do_reset();
    lim0 = 14'd300; lim1 = 14'd600; lim2 = 14'd900;
    feed(3, 1, 1'b0);
    verify("gradient", 1);
  endtask

  task automatic t_bands();
    do_reset();
    lim0 = 14'd100; lim1 = 14'd400; lim2 = 14'd800;
    feed(4, 1, 1'b0);
    verify("bands", 1);
  endtask

  task automatic t_gaps();
    do_reset();
    lim0 = 14'd1500; lim1 = 14'd2500; lim2 = 14'd3500;
    feed(1, 1, 1'b1);
    verify("idle-gaps R6", 1);
  endtask

  task automatic t_two_frames();
    do_reset();
    lim0 = 14'd1500; lim1 = 14'd2500; lim2 = 14'd3500;
    feed(1, 2, 1'b0);
    verify("back-to-back", 2);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_latency();
    t_flat_boundary();
    t_random();
    t_checker();
    t_gradient();
    t_bands();
    t_gaps();
    t_two_frames();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule